// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block turns requests from an internal master into cycles on an external memory bus. The external address window is cut into four equal regions. Each region has its own active-low select line and its own settings: data width (8 or 16 bits), byte order of multi-byte data, address/data format (separate lines or address multiplexed onto the data lines) and the number of wait cycles inside the strobe.

The internal side uses a single valid/ready request channel and a one-cycle response pulse. A write is posted. It is answered in the cycle after it is taken, while the external cycle carries on. The controller takes no further request until that cycle has finished, so a read issued behind a posted write always sees the written data. A request whose address lies outside the four regions is answered with an error, and no select line moves. Region settings are written through a small configuration port. They are copied when a request is accepted, so a change never disturbs a cycle that is already running.

Top module: `xbus_cs_ctrl`

## Requirements
- R1: Internal address bits [25:24] pick region k, and bits [23:0] give the external offset on `ext_addr`. `ext_cs_n[k]` is low only while an external cycle to region k is in progress. At most one select is low at any time. A strobe (`ext_rd_n`/`ext_wr_n`) is low only while a select is low.
- R2: A configuration write with `cfg_we` high stores `cfg_wdata` for region `cfg_area`. The fields are: bit0 = 16-bit width, bit1 = big-endian data, bit2 = multiplexed format, bits[5:3] = wait count. After reset every region is 8-bit, little-endian, separate format, 7 waits. Settings are copied when a request is accepted.
- R3: A 16-bit access (`in_half`=1) to an 8-bit region becomes two byte cycles, at offset and offset+1, on `ext_dout[7:0]`/`ext_din[7:0]`.
- R4: With little-endian data, the byte at the lower address is data[7:0]. With big-endian data it is data[15:8]. On a 16-bit region a 16-bit access in big-endian mode swaps the two lanes. Addresses and byte accesses are never altered by the byte-order setting.
- R5: On a 16-bit region, lane 0 (`ext_dout[7:0]`) carries even addresses and lane 1 carries odd ones. A byte access uses lane `addr[0]`. `ext_be_n` is active low per lane and enables only that lane. A 16-bit access enables both lanes.
- R6: In multiplexed format every byte or word cycle starts with one address phase: `ext_ale` is high, `ext_doe` is high and `ext_dout` carries `ext_addr[15:0]`.
- R7: Each cycle has one setup clock, then the strobe is held low for waits+1 clocks. Address and data stay stable while the strobe is low.
- R8: A write to a valid region is answered (`rsp_valid`=1, `rsp_err`=0) in the clock after acceptance, while its external cycle is still running.
- R9: `in_ready` is low while any external cycle is running. A read that follows a posted write starts only after the write has completed and returns the written data.
- R10: A request with internal address bits above bit 25 non-zero is answered in the next clock with `rsp_err`=1, and no select line is asserted.
- R11: A read is answered with `rsp_valid` in the clock after its last strobe clock, with the assembled data in `rsp_rdata` (a byte read returns it in bits [7:0] with zero above).
- R12: During and after reset, all selects and strobes are high, `ext_ale` is low, `in_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_area | input | 2 | Region written by the configuration port |
| cfg_wdata | input | 6 | Region settings (see R2) |
| in_valid | input | 1 | Internal request valid |
| in_ready | output | 1 | Controller can take a request |
| in_write | input | 1 | 1 = write, 0 = read |
| in_half | input | 1 | 1 = 16-bit access, 0 = byte access |
| in_addr | input | 28 | Internal byte address |
| in_wdata | input | 16 | Write data (byte in bits [7:0]) |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_err | output | 1 | Response is an address error |
| rsp_rdata | output | 16 | Read data |
| ext_cs_n | output | 4 | Active-low select per region |
| ext_addr | output | 24 | External address |
| ext_dout | output | 16 | Data (or address phase) driven out |
| ext_doe | output | 1 | Output enable for ext_dout |
| ext_din | input | 16 | Data read from the bus |
| ext_ale | output | 1 | Address strobe in multiplexed format |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_be_n | output | 2 | Active-low lane enables |

## Verification
The assertions check on every clock the rules that hold for any traffic. At most one select is low at a time. Strobes and the address phase appear only under a select. A strobe never runs longer than the largest wait setting allows, and the address holds steady while a strobe is low. The controller stays busy while the bus is in use, and posted-write and error responses arrive at their fixed moment. Only the bench scenarios can show the data path: byte order and lane choice, the split of a wide access into two byte cycles, the exact strobe length for each wait setting, the address phase contents, and a read after a posted write returning fresh data. Each of these is checked against a memory model attached to the pins.

// File: rtl/xbus_pkg.sv
// Package: shared types for the external bus chip-select controller.
// Assumes a 16-bit external data path and a 3-bit wait field.
package xbus_pkg;
    localparam int WAIT_W = 3;
    localparam int DATA_W = 16;

    // Per-region settings, packed so bit0 = width, bit1 = byte order,
    // bit2 = multiplexed format, bits[5:3] = wait count.
    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              mux;
        logic              big;
        logic              w16;
    } area_cfg_t;

    localparam area_cfg_t CFG_RESET = '{waits: {WAIT_W{1'b1}}, mux: 1'b0, big: 1'b0, w16: 1'b0};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALE   = 2'd1,
        ST_SETUP = 2'd2,
        ST_STRB  = 2'd3
    } bus_st_t;
endpackage

// File: rtl/xbus_cfg_bank.sv
// Module: holds one settings word per region, written through a simple
// write strobe. Assumes writes may arrive at any time; users copy the
// value at request acceptance.
module xbus_cfg_bank
    import xbus_pkg::*;
#(
    parameter int N_AREAS = 4,
    localparam int SEL_W = $clog2(N_AREAS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [SEL_W-1:0]        sel,
    input  area_cfg_t               wdata,
    output area_cfg_t [N_AREAS-1:0] cfg_o
);
    for (genvar g = 0; g < N_AREAS; g++) begin : g_area
        // Settings register of region g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[g] <= CFG_RESET;
            end else if (we && (sel == SEL_W'(g))) begin
                cfg_o[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/xbus_decode.sv
// Module: splits an internal address into region index and offset and
// flags addresses above the external window. Purely combinational.
module xbus_decode #(
    parameter int ADDR_W  = 28,
    parameter int OFS_W   = 24,
    parameter int N_AREAS = 4,
    localparam int SEL_W  = $clog2(N_AREAS),
    localparam int TOP_W  = ADDR_W - OFS_W - SEL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SEL_W-1:0]  area,
    output logic [OFS_W-1:0]  ofs
);
    assign ofs  = addr[OFS_W-1:0];
    assign area = addr[OFS_W +: SEL_W];

    if (TOP_W > 0) begin : g_top
        assign hit = (addr[ADDR_W-1 -: TOP_W] == '0);
    end else begin : g_notop
        assign hit = 1'b1;
    end
endmodule

// File: rtl/xbus_lanes.sv
// Module: steers write data onto the external lanes and merges read data
// back, following width, byte order and beat number. Assumes 16-bit
// accesses are aligned to even addresses.
module xbus_lanes
    import xbus_pkg::*;
(
    input  logic              w16,
    input  logic              big,
    input  logic              half,
    input  logic              a0,
    input  logic              beat,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] racc,
    output logic [DATA_W-1:0] dout,
    output logic [1:0]        be_n,
    output logic [DATA_W-1:0] rnext
);
    logic sel_hi;

    // Lane choice and byte-order steering for the current beat.
    always_comb begin
        sel_hi = beat ^ big;
        dout   = '0;
        be_n   = 2'b11;
        rnext  = racc;
        if (w16) begin
            if (half) begin
                dout  = big ? {wdata[7:0], wdata[15:8]} : wdata;
                be_n  = 2'b00;
                rnext = big ? {din[7:0], din[15:8]} : din;
            end else begin
                dout  = {wdata[7:0], wdata[7:0]};
                be_n  = a0 ? 2'b01 : 2'b10;
                rnext = {8'h00, a0 ? din[15:8] : din[7:0]};
            end
        end else begin
            be_n = 2'b10;
            if (half) begin
                dout  = {8'h00, sel_hi ? wdata[15:8] : wdata[7:0]};
                rnext = sel_hi ? {din[7:0], racc[7:0]} : {racc[15:8], din[7:0]};
            end else begin
                dout  = {8'h00, wdata[7:0]};
                rnext = {8'h00, din[7:0]};
            end
        end
    end
endmodule

// File: rtl/xbus_cs_ctrl.sv
// Module: top of the external bus chip-select controller. Takes one
// internal request at a time, posts writes, and runs the per-region
// external cycle (address phase, setup, strobe with waits). Assumes
// OFS_W >= 16 and aligned 16-bit accesses.
module xbus_cs_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W  = 28,
    parameter int OFS_W   = 24,
    parameter int N_AREAS = 4,
    localparam int SEL_W  = $clog2(N_AREAS),
    localparam int CFG_W  = $bits(area_cfg_t)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_area,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_write,
    input  logic               in_half,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [DATA_W-1:0]  in_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic [N_AREAS-1:0] ext_cs_n,
    output logic [OFS_W-1:0]   ext_addr,
    output logic [DATA_W-1:0]  ext_dout,
    output logic               ext_doe,
    input  logic [DATA_W-1:0]  ext_din,
    output logic               ext_ale,
    output logic               ext_rd_n,
    output logic               ext_wr_n,
    output logic [1:0]         ext_be_n
);
    area_cfg_t [N_AREAS-1:0] cfg_all;
    logic                    dec_hit;
    logic [SEL_W-1:0]        dec_area;
    logic [OFS_W-1:0]        dec_ofs;

    bus_st_t           st_q;
    area_cfg_t         cur_q;
    logic [SEL_W-1:0]  area_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              wr_q;
    logic              half_q;
    logic [DATA_W-1:0] wdata_q;
    logic              beat_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic [DATA_W-1:0] racc_q;
    logic              rsp_valid_q;
    logic              rsp_err_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    logic [DATA_W-1:0] lane_dout;
    logic [1:0]        lane_be_n;
    logic [DATA_W-1:0] lane_rnext;
    logic              accept;
    logic              last_beat;
    logic              strb_done;
    logic              busy;

    xbus_cfg_bank #(.N_AREAS(N_AREAS)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_area),
        .wdata (area_cfg_t'(cfg_wdata)),
        .cfg_o (cfg_all)
    );

    xbus_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .N_AREAS(N_AREAS)) u_dec (
        .addr (in_addr),
        .hit  (dec_hit),
        .area (dec_area),
        .ofs  (dec_ofs)
    );

    xbus_lanes u_lanes (
        .w16   (cur_q.w16),
        .big   (cur_q.big),
        .half  (half_q),
        .a0    (ofs_q[0]),
        .beat  (beat_q),
        .wdata (wdata_q),
        .din   (ext_din),
        .racc  (racc_q),
        .dout  (lane_dout),
        .be_n  (lane_be_n),
        .rnext (lane_rnext)
    );

    assign busy      = (st_q != ST_IDLE);
    assign in_ready  = !busy;
    assign accept    = in_valid && in_ready;
    assign last_beat = !(half_q && !cur_q.w16) || beat_q;
    assign strb_done = (wcnt_q == cur_q.waits);

    // Request sequencer: accept, address phase, setup, strobe and beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            cur_q       <= CFG_RESET;
            area_q      <= '0;
            ofs_q       <= '0;
            wr_q        <= 1'b0;
            half_q      <= 1'b0;
            wdata_q     <= '0;
            beat_q      <= 1'b0;
            wcnt_q      <= '0;
            racc_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (!dec_hit) begin
                            rsp_valid_q <= 1'b1;
                            rsp_err_q   <= 1'b1;
                        end else begin
                            cur_q   <= cfg_all[dec_area];
                            area_q  <= dec_area;
                            ofs_q   <= dec_ofs;
                            wr_q    <= in_write;
                            half_q  <= in_half;
                            wdata_q <= in_wdata;
                            beat_q  <= 1'b0;
                            st_q    <= cfg_all[dec_area].mux ? ST_ALE : ST_SETUP;
                            if (in_write) begin
                                rsp_valid_q <= 1'b1;
                                rsp_err_q   <= 1'b0;
                            end
                        end
                    end
                end
                ST_ALE: begin
                    st_q <= ST_SETUP;
                end
                ST_SETUP: begin
                    wcnt_q <= '0;
                    st_q   <= ST_STRB;
                end
                ST_STRB: begin
                    if (!strb_done) begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end else begin
                        if (!wr_q) begin
                            racc_q <= lane_rnext;
                        end
                        if (last_beat) begin
                            st_q <= ST_IDLE;
                            if (!wr_q) begin
                                rsp_valid_q <= 1'b1;
                                rsp_err_q   <= 1'b0;
                                rsp_rdata_q <= lane_rnext;
                            end
                        end else begin
                            beat_q <= 1'b1;
                            st_q   <= cur_q.mux ? ST_ALE : ST_SETUP;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < N_AREAS; g++) begin : g_cs
        // Select line of region g, low for the whole external cycle.
        assign ext_cs_n[g] = !(busy && (area_q == SEL_W'(g)));
    end

    // External pin drive derived from the sequencer state.
    always_comb begin
        ext_addr = ofs_q + OFS_W'(beat_q);
        ext_ale  = (st_q == ST_ALE);
        ext_dout = ext_ale ? ext_addr[DATA_W-1:0] : lane_dout;
        ext_doe  = ext_ale || (wr_q && ((st_q == ST_SETUP) || (st_q == ST_STRB)));
        ext_rd_n = !((st_q == ST_STRB) && !wr_q);
        ext_wr_n = !((st_q == ST_STRB) && wr_q);
        ext_be_n = busy ? lane_be_n : 2'b11;
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_err   = rsp_err_q;
    assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/xbus_cs_ctrl_chk.sv
// Module: property checker bound to the controller top. Observes ports
// only; holds a strobe-length counter for the wait bound.
module xbus_cs_ctrl_chk
    import xbus_pkg::*;
#(
    parameter int ADDR_W  = 28,
    parameter int OFS_W   = 24,
    parameter int N_AREAS = 4,
    localparam int SEL_W  = $clog2(N_AREAS),
    localparam int CFG_W  = $bits(area_cfg_t)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [SEL_W-1:0]   cfg_area,
    input logic [CFG_W-1:0]   cfg_wdata,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_write,
    input logic               in_half,
    input logic [ADDR_W-1:0]  in_addr,
    input logic [DATA_W-1:0]  in_wdata,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic [N_AREAS-1:0] ext_cs_n,
    input logic [OFS_W-1:0]   ext_addr,
    input logic [DATA_W-1:0]  ext_dout,
    input logic               ext_doe,
    input logic [DATA_W-1:0]  ext_din,
    input logic               ext_ale,
    input logic               ext_rd_n,
    input logic               ext_wr_n,
    input logic [1:0]         ext_be_n
);
    localparam int TOP_LO = OFS_W + SEL_W;
    localparam int RUN_W  = WAIT_W + 2;

    logic             in_range;
    logic             strobe_low;
    logic [RUN_W-1:0] run_q;

    assign in_range   = (in_addr[ADDR_W-1:TOP_LO] == '0);
    assign strobe_low = !ext_rd_n || !ext_wr_n;

    // Counts consecutive clocks with a strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= strobe_low ? run_q + 1'b1 : '0;
    end

    p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    p_strobe_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low |-> !(&ext_cs_n));

    p_ale_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ale |-> (ext_doe && ext_rd_n && ext_wr_n && !(&ext_cs_n)));

    p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(2 ** WAIT_W));

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_low && $past(strobe_low)) |-> $stable(ext_addr));

    p_post_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_write && in_range) |=> (rsp_valid && !rsp_err));

    p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(&ext_cs_n) |-> !in_ready);

    p_oor_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_range) |=> (rsp_valid && rsp_err && (&ext_cs_n)));
endmodule

bind xbus_cs_ctrl xbus_cs_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .OFS_W   (OFS_W),
    .N_AREAS (N_AREAS)
) u_chk (.*);

// File: tb/sim_xbus_cs_ctrl.sv
// Directed bench with a pin-level memory model per region.
module sim_xbus_cs_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_area = '0;
    logic [5:0]  cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_write = 1'b0;
    logic        in_half = 1'b0;
    logic [27:0] in_addr = '0;
    logic [15:0] in_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic [3:0]  ext_cs_n;
    logic [23:0] ext_addr;
    logic [15:0] ext_dout;
    logic        ext_doe;
    logic [15:0] ext_din;
    logic        ext_ale, ext_rd_n, ext_wr_n;
    logic [1:0]  ext_be_n;

    int n_checks = 0;
    int n_fail = 0;

    logic [7:0] mem [0:3][0:255];
    logic       tb_w16 [0:3];

    int          cyc = 0;
    int          run = 0;
    int          last_run = 0;
    int          beats = 0;
    logic [23:0] beat_addr [0:3];
    int          ale_cnt = 0;
    logic [15:0] ale_dout = '0;
    int          cs_low_cnt = 0;
    logic [3:0]  last_cs = 4'h0;
    logic        prev_low = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_cs_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_area(cfg_area),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_write(in_write), .in_half(in_half), .in_addr(in_addr),
        .in_wdata(in_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .ext_cs_n(ext_cs_n), .ext_addr(ext_addr),
        .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din),
        .ext_ale(ext_ale), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_be_n(ext_be_n)
    );

    // Memory read path: the selected region drives its bytes.
    always_comb begin
        int k;
        logic [7:0] a;
        k = -1;
        a = ext_addr[7:0];
        for (int i = 0; i < 4; i++) if (!ext_cs_n[i]) k = i;
        ext_din = 16'h0000;
        if (k >= 0) begin
            if (tb_w16[k]) ext_din = {mem[k][{a[7:1], 1'b1}], mem[k][{a[7:1], 1'b0}]};
            else           ext_din = {8'h00, mem[k][a]};
        end
    end

    // Pin monitor and memory write path, sampled mid-cycle.
    always @(negedge clk) begin
        logic low;
        logic [7:0] a;
        int k;
        cyc++;
        a = ext_addr[7:0];
        k = -1;
        for (int i = 0; i < 4; i++) if (!ext_cs_n[i]) k = i;
        if (k >= 0) begin
            cs_low_cnt++;
            last_cs = ~ext_cs_n;
        end
        if (!ext_wr_n && k >= 0) begin
            if (tb_w16[k]) begin
                if (!ext_be_n[0]) mem[k][{a[7:1], 1'b0}] = ext_dout[7:0];
                if (!ext_be_n[1]) mem[k][{a[7:1], 1'b1}] = ext_dout[15:8];
            end else begin
                mem[k][a] = ext_dout[7:0];
            end
        end
        low = !ext_rd_n || !ext_wr_n;
        if (low) begin
            if (!prev_low) begin
                beat_addr[beats % 4] = ext_addr;
                beats++;
            end
            run++;
        end else if (prev_low) begin
            last_run = run;
            run = 0;
        end
        prev_low = low;
        if (ext_ale) begin
            ale_cnt++;
            ale_dout = ext_dout;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_area(input int k, input logic w16, input logic big, input logic mux, input logic [2:0] waits);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_area  = 2'(k);
        cfg_wdata = {waits, mux, big, w16};
        tb_w16[k] = w16;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic wr, input logic half, input logic [27:0] addr, input logic [15:0] wd,
                          output logic [15:0] rd, output logic err, output int lat, output logic busy_at_rsp);
        in_valid = 1'b1;
        in_write = wr;
        in_half  = half;
        in_addr  = addr;
        in_wdata = wd;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        err = rsp_err;
        busy_at_rsp = !(&ext_cs_n) && !in_ready;
    endtask

    task automatic wait_idle();
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [27:0] mk(input int k, input logic [23:0] ofs);
        return {2'b00, 2'(k), ofs};
    endfunction

    task automatic t_reset();
        check(ext_cs_n == 4'hF, "R12 cs idle", 32'(ext_cs_n), 32'hF);
        check(ext_rd_n && ext_wr_n && !ext_ale, "R12 strobes idle", {29'd0, ext_rd_n, ext_wr_n, ext_ale}, 32'h6);
        check(in_ready && !rsp_valid, "R12 ready/rsp", {30'd0, in_ready, rsp_valid}, 32'h2);
    endtask

    task automatic t_default_post();
        logic [15:0] rd; logic err, busy; int lat;
        access(1'b1, 1'b0, mk(0, 24'h000010), 16'h005A, rd, err, lat, busy);
        check(lat == 1 && !err, "R8 write answered next clock", 32'(lat), 32'd1);
        check(busy, "R8 external cycle still running at response", 32'(busy), 32'd1);
        wait_idle();
        check(mem[0][8'h10] == 8'h5A, "R1 byte written in region 0", 32'(mem[0][8'h10]), 32'h5A);
        check(last_run == 8, "R2 reset waits 7 give 8 strobe clocks", 32'(last_run), 32'd8);
        check(last_cs == 4'b0001, "R1 region 0 select", 32'(last_cs), 32'h1);
    endtask

    task automatic t_split_little();
        logic [15:0] rd; logic err, busy; int lat; int b0;
        set_area(1, 1'b0, 1'b0, 1'b0, 3'd0);
        b0 = beats;
        access(1'b1, 1'b1, mk(1, 24'h000020), 16'hBEEF, rd, err, lat, busy);
        wait_idle();
        check(beats - b0 == 2, "R3 two byte cycles", 32'(beats - b0), 32'd2);
        check(beat_addr[b0 % 4] == 24'h20 && beat_addr[(b0 + 1) % 4] == 24'h21, "R3 beat addresses",
              {8'h0, beat_addr[(b0 + 1) % 4]}, 32'h21);
        check(mem[1][8'h20] == 8'hEF && mem[1][8'h21] == 8'hBE, "R4 little order in 8-bit region",
              {mem[1][8'h21], mem[1][8'h20]}, 32'hBEEF);
        check(last_run == 1, "R7 zero waits give one strobe clock", 32'(last_run), 32'd1);
        check(last_cs == 4'b0010, "R1 region 1 select", 32'(last_cs), 32'h2);
    endtask

    task automatic t_split_big();
        logic [15:0] rd; logic err, busy; int lat;
        set_area(2, 1'b0, 1'b1, 1'b0, 3'd2);
        access(1'b1, 1'b1, mk(2, 24'h000040), 16'h1234, rd, err, lat, busy);
        wait_idle();
        check(mem[2][8'h40] == 8'h12 && mem[2][8'h41] == 8'h34, "R4 big order in 8-bit region",
              {mem[2][8'h40], mem[2][8'h41]}, 32'h1234);
        check(last_run == 3, "R7 two waits give three strobe clocks", 32'(last_run), 32'd3);
        access(1'b0, 1'b1, mk(2, 24'h000040), 16'h0000, rd, err, lat, busy);
        check(rd == 16'h1234 && !err, "R11 R4 big read reassembled", 32'(rd), 32'h1234);
        wait_idle();
    endtask

    task automatic t_wide();
        logic [15:0] rd; logic err, busy; int lat; int b0;
        set_area(3, 1'b1, 1'b0, 1'b0, 3'd1);
        access(1'b1, 1'b1, mk(3, 24'h000080), 16'hA1B2, rd, err, lat, busy);
        wait_idle();
        check(mem[3][8'h80] == 8'hB2 && mem[3][8'h81] == 8'hA1, "R5 both lanes written",
              {mem[3][8'h81], mem[3][8'h80]}, 32'hA1B2);
        access(1'b1, 1'b0, mk(3, 24'h000083), 16'h0077, rd, err, lat, busy);
        wait_idle();
        check(mem[3][8'h83] == 8'h77, "R5 odd byte on lane 1", 32'(mem[3][8'h83]), 32'h77);
        check(mem[3][8'h82] == 8'h00, "R5 other lane disabled", 32'(mem[3][8'h82]), 32'h00);
        access(1'b0, 1'b0, mk(3, 24'h000083), 16'h0000, rd, err, lat, busy);
        check(rd == 16'h0077, "R5 R11 byte read from lane 1", 32'(rd), 32'h0077);
        check(lat == 4, "R11 read response after setup and two strobe clocks", 32'(lat), 32'd4);
        wait_idle();
        set_area(3, 1'b1, 1'b1, 1'b0, 3'd1);
        b0 = beats;
        access(1'b0, 1'b1, mk(3, 24'h000080), 16'h0000, rd, err, lat, busy);
        check(rd == 16'hB2A1, "R4 big swaps lanes on 16-bit region", 32'(rd), 32'hB2A1);
        check(beat_addr[b0 % 4] == 24'h80, "R4 address not swapped", {8'h0, beat_addr[b0 % 4]}, 32'h80);
        wait_idle();
    endtask

    task automatic t_mux();
        logic [15:0] rd; logic err, busy; int lat; int a0;
        set_area(0, 1'b0, 1'b0, 1'b1, 3'd0);
        a0 = ale_cnt;
        access(1'b1, 1'b0, mk(0, 24'h001234), 16'h003C, rd, err, lat, busy);
        wait_idle();
        check(ale_cnt - a0 == 1, "R6 one address phase", 32'(ale_cnt - a0), 32'd1);
        check(ale_dout == 16'h1234, "R6 address on data lines", 32'(ale_dout), 32'h1234);
        check(mem[0][8'h34] == 8'h3C, "R6 data after address phase", 32'(mem[0][8'h34]), 32'h3C);
        a0 = ale_cnt;
        access(1'b0, 1'b1, mk(0, 24'h001234), 16'h0000, rd, err, lat, busy);
        check(lat == 7, "R6 R11 two beats each with address phase", 32'(lat), 32'd7);
        check(ale_cnt - a0 == 2 && ale_dout == 16'h1235, "R6 second address phase", 32'(ale_dout), 32'h1235);
        wait_idle();
    endtask

    task automatic t_error();
        logic [15:0] rd; logic err, busy; int lat; int c0;
        c0 = cs_low_cnt;
        access(1'b0, 1'b0, 28'h4000010, 16'h0000, rd, err, lat, busy);
        check(err && lat == 1, "R10 error response next clock", {31'd0, err}, 32'd1);
        repeat (3) @(negedge clk);
        check(cs_low_cnt == c0, "R10 no select asserted", 32'(cs_low_cnt - c0), 32'd0);
    endtask

    task automatic t_raw();
        logic [15:0] rd; logic err, busy; int lat;
        set_area(1, 1'b0, 1'b0, 1'b0, 3'd5);
        access(1'b1, 1'b1, mk(1, 24'h000050), 16'hC0DE, rd, err, lat, busy);
        check(busy, "R9 controller busy after posted write", 32'(busy), 32'd1);
        access(1'b0, 1'b1, mk(1, 24'h000050), 16'h0000, rd, err, lat, busy);
        check(rd == 16'hC0DE, "R9 read after posted write sees new data", 32'(rd), 32'hC0DE);
        wait_idle();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) tb_w16[i] = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_post();
        t_split_little();
        t_split_big();
        t_wide();
        t_mux();
        t_error();
        t_raw();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule